// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is an integer register file that gives each procedure its own set of registers without copying anything. It holds a group of global registers and a ring of windows. A current-window pointer picks the window that the 32 architectural register numbers address. Neighbouring windows overlap. The registers a caller writes as its outgoing arguments are the same physical registers the callee reads as its incoming arguments once the pointer has moved. Two combinational read ports and one write port are addressed through the pointer.

A save command moves the pointer down by one window and a restore command moves it up by one. Both wrap around the ring. A per-window invalid mask guards the ring. A save or restore whose target window is marked invalid moves nothing and raises an overflow or underflow flag in the same cycle, so that a trap handler can spill or fill. A synchronous load port lets that handler replace the pointer and the mask.

Top module: `winreg_file`

## Requirements
- R1: After reset the pointer is 0, the invalid mask is 8'b0000_0010 (only window 1 marked invalid), and every register reads 0.
- R2: Architectural registers 0 to 7 are globals. They address the same physical registers in every window.
- R3: Register 0 always reads as 0. A write to register 0 has no effect.
- R4: The ins (registers 24 to 31) of window w are the same physical registers as the outs (registers 8 to 15) of window (w+1) mod NWIN. A value written as an out is read back as the matching in after a save, and the reverse holds after a restore. This includes the wrap between window NWIN-1 and window 0.
- R5: The locals (registers 16 to 23) of each window are private to that window.
- R6: A save whose target window (pointer-1, with 0 wrapping to NWIN-1) is valid decrements the pointer at the clock edge.
- R7: A restore whose target window (pointer+1, with NWIN-1 wrapping to 0) is valid increments the pointer at the clock edge.
- R8: A save whose target window has its mask bit set drives ovf_trap high in that cycle and leaves the pointer unchanged.
- R9: A restore whose target window has its mask bit set drives unf_trap high in that cycle and leaves the pointer unchanged.
- R10: Reads in the cycle of a save or restore use the old pointer. A write in that cycle is addressed through the old pointer. A write becomes readable in the next cycle.
- R11: When ld_en is high, the pointer and the mask take ld_ptr and ld_mask at the edge. The load overrides save and restore, and no trap is raised in that cycle. ld_ptr must be below NWIN.
- R12: When save and restore are requested together without a load, neither acts. The pointer holds and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_a_data | output | DW | Read data, port A |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| ld_en | input | 1 | Load pointer and mask |
| ld_ptr | input | PTRW | Pointer value to load |
| ld_mask | input | NWIN | Invalid mask to load |
| cur_ptr | output | PTRW | Current window pointer |
| inv_mask | output | NWIN | Current invalid mask |
| ovf_trap | output | 1 | Save blocked by an invalid target window |
| unf_trap | output | 1 | Restore blocked by an invalid target window |

## Verification
The hardest state to reach is a ring that is fully wrapped, with the pointer sitting next to the guard window. From reset this takes a chain of saves with data carried through the overlaps. The stimulus walks the pointer down from window 0 through the wrap to window 7 and on to window 2, where the next save must trap. It then climbs back through the wrap to window 0, where the next restore must trap. The load port then places the pointer and the mask directly. This sets up the last-window-to-window-0 aliasing, and a load cycle also carries a save, which the load must override.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int ARCH_W   = 5;
    localparam int GRP_SIZE = 8;
    localparam int WIN_REGS = 2 * GRP_SIZE;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;
endpackage

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl #(
    parameter int NWIN = 8,
    parameter int PTRW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            ld_en,
    input  logic [PTRW-1:0] ld_ptr,
    input  logic [NWIN-1:0] ld_mask,
    output logic [PTRW-1:0] ptr_o,
    output logic [NWIN-1:0] mask_o,
    output logic            ovf_o,
    output logic            unf_o
);
    localparam logic [NWIN-1:0] RST_MASK = NWIN'(2);
    localparam logic [PTRW-1:0] TOP_PTR  = PTRW'(NWIN - 1);

    typedef struct packed {
        logic [PTRW-1:0] ptr;
        logic [NWIN-1:0] mask;
    } ctl_t;

    ctl_t            st_d, st_q;
    logic [PTRW-1:0] dn_ptr, up_ptr;
    logic            do_save, do_restore;

    always_comb begin
        st_d       = st_q;
        dn_ptr     = (st_q.ptr == '0) ? TOP_PTR : st_q.ptr - 1'b1;
        up_ptr     = (st_q.ptr == TOP_PTR) ? '0 : st_q.ptr + 1'b1;
        do_save    = save_req & ~restore_req & ~ld_en;
        do_restore = restore_req & ~save_req & ~ld_en;
        ovf_o      = do_save & st_q.mask[dn_ptr];
        unf_o      = do_restore & st_q.mask[up_ptr];
        if (ld_en) begin
            st_d.ptr  = ld_ptr;
            st_d.mask = ld_mask;
        end else if (do_save && !ovf_o) begin
            st_d.ptr = dn_ptr;
        end else if (do_restore && !unf_o) begin
            st_d.ptr = up_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.mask <= RST_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o  = st_q.ptr;
    assign mask_o = st_q.mask;

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ptr_o == $past(ptr_o));
    // R9
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> ptr_o == $past(ptr_o));
    // R6
    save_lands_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && !ld_en && !ovf_o) |=> (!mask_o[ptr_o] && ptr_o != $past(ptr_o)));
    // R7
    restore_lands_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !ld_en && !unf_o) |=> (!mask_o[ptr_o] && ptr_o != $past(ptr_o)));
    // R12
    pair_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req && !ld_en) |=> $stable(ptr_o));
    // R11
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> (!ovf_o && !unf_o));
endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int PTRW  = $clog2(NWIN),
    parameter int PIDXW = $clog2(GRP_SIZE + WIN_REGS * NWIN)
) (
    input  logic [ARCH_W-1:0] arch_idx,
    input  logic [PTRW-1:0]   ptr,
    output logic [PIDXW-1:0]  phys_idx
);
    localparam logic [PTRW-1:0] TOP_PTR = PTRW'(NWIN - 1);

    reg_grp_e        grp;
    logic [PTRW-1:0] nbr_ptr;
    int              base;

    always_comb begin
        grp     = reg_grp_e'(arch_idx[ARCH_W-1:ARCH_W-2]);
        nbr_ptr = (ptr == TOP_PTR) ? '0 : ptr + 1'b1;
        unique case (grp)
            GRP_GLOBAL: base = 0;
            GRP_OUT:    base = GRP_SIZE + WIN_REGS * int'(ptr);
            GRP_LOCAL:  base = 2 * GRP_SIZE + WIN_REGS * int'(ptr);
            default:    base = GRP_SIZE + WIN_REGS * int'(nbr_ptr);
        endcase
        phys_idx = PIDXW'(base + int'(arch_idx[2:0]));
    end
endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
    parameter int DEPTH = 136,
    parameter int DW    = 32,
    parameter int PIDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIDXW-1:0] raddr_a,
    input  logic [PIDXW-1:0] raddr_b,
    output logic [DW-1:0]    rdata_a,
    output logic [DW-1:0]    rdata_b,
    input  logic             we,
    input  logic [PIDXW-1:0] waddr,
    input  logic [DW-1:0]    wdata
);
    logic [DW-1:0] regs_d [DEPTH];
    logic [DW-1:0] regs_q [DEPTH];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{default: '0};
        else        regs_q <= regs_d;
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    // R3
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr != '0);
    // R10
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32,
    parameter int PTRW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    input  logic [4:0]      rd_b_idx,
    output logic [DW-1:0]   rd_a_data,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            ld_en,
    input  logic [PTRW-1:0] ld_ptr,
    input  logic [NWIN-1:0] ld_mask,
    output logic [PTRW-1:0] cur_ptr,
    output logic [NWIN-1:0] inv_mask,
    output logic            ovf_trap,
    output logic            unf_trap
);
    localparam int DEPTH  = GRP_SIZE + WIN_REGS * NWIN;
    localparam int PIDXW  = $clog2(DEPTH);
    localparam int NPORTS = 3;

    logic [NPORTS-1:0][ARCH_W-1:0] arch_idx;
    logic [NPORTS-1:0][PIDXW-1:0]  phys_idx;
    logic                          wr_live;

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;
    assign wr_live     = wr_en && (wr_idx != '0);

    wrf_win_ctrl #(.NWIN(NWIN), .PTRW(PTRW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req),
        .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_mask(ld_mask),
        .ptr_o(cur_ptr), .mask_o(inv_mask),
        .ovf_o(ovf_trap), .unf_o(unf_trap)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN), .PTRW(PTRW), .PIDXW(PIDXW)) u_map (
            .arch_idx(arch_idx[p]),
            .ptr(cur_ptr),
            .phys_idx(phys_idx[p])
        );
    end

    wrf_bank #(.DEPTH(DEPTH), .DW(DW), .PIDXW(PIDXW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .raddr_a(phys_idx[0]), .raddr_b(phys_idx[1]),
        .rdata_a(rd_a_data), .rdata_b(rd_b_data),
        .we(wr_live), .waddr(phys_idx[2]), .wdata(wr_data)
    );

    // R3
    zero_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0));
endmodule

// File: tb/test_winreg_file.sv
`timescale 1ns/1ps
module test_winreg_file;
    localparam int NWIN  = 8;
    localparam int DW    = 32;
    localparam int PTRW  = 3;
    localparam int NPHYS = 8 + 16 * NWIN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0]   rd_a_data, rd_b_data, wr_data = '0;
    logic            wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, ld_en = 1'b0;
    logic [PTRW-1:0] ld_ptr = '0, cur_ptr;
    logic [NWIN-1:0] ld_mask = '0, inv_mask;
    logic            ovf_trap, unf_trap;

    winreg_file #(.NWIN(NWIN), .DW(DW)) i_winreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_mask(ld_mask),
        .cur_ptr(cur_ptr), .inv_mask(inv_mask),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    always #2 clk = ~clk;

    typedef struct {
        int              req;
        logic [DW-1:0]   a, b;
        logic [PTRW-1:0] ptr;
        logic [NWIN-1:0] mask;
        logic            ovf, unf;
    } exp_t;

    exp_t            sb_q[$];
    logic [DW-1:0]   gold [NPHYS];
    int              g_ptr = 0;
    logic [NWIN-1:0] g_mask = 8'b0000_0010;
    int              n_chk = 0, n_fail = 0;

    function automatic int gmap(input int idx, input int p);
        if (idx < 8)  return idx;
        if (idx < 16) return 8 + 16 * p + (idx - 8);
        if (idx < 24) return 8 + 16 * p + (idx - 8);
        return 8 + 16 * ((p + 1) % NWIN) + (idx - 24);
    endfunction

    task automatic chk(input int req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, push the expected outputs, advance the model
    task automatic cyc(input int req, input bit sv, input bit rs, input bit we,
                       input int wi, input logic [DW-1:0] wd, input int ra, input int rb,
                       input bit ld = 1'b0, input int lp = 0, input logic [NWIN-1:0] lm = '0);
        exp_t e;
        int   dn, up;
        @(posedge clk); #1;
        save_req = sv; restore_req = rs; wr_en = we; wr_idx = 5'(wi); wr_data = wd;
        rd_a_idx = 5'(ra); rd_b_idx = 5'(rb); ld_en = ld; ld_ptr = PTRW'(lp); ld_mask = lm;
        dn = (g_ptr + NWIN - 1) % NWIN;
        up = (g_ptr + 1) % NWIN;
        e.req  = req;
        e.a    = gold[gmap(ra, g_ptr)];
        e.b    = gold[gmap(rb, g_ptr)];
        e.ptr  = PTRW'(g_ptr);
        e.mask = g_mask;
        e.ovf  = sv && !rs && !ld && g_mask[dn];
        e.unf  = rs && !sv && !ld && g_mask[up];
        sb_q.push_back(e);
        if (we && wi != 0) gold[gmap(wi, g_ptr)] = wd;
        if (ld) begin
            g_ptr = lp; g_mask = lm;
        end else if (sv && !rs && !e.ovf) g_ptr = dn;
        else if (rs && !sv && !e.unf) g_ptr = up;
    endtask

    // monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(e.req, "rd_a_data", rd_a_data, e.a);
            chk(e.req, "rd_b_data", rd_b_data, e.b);
            chk(e.req, "cur_ptr", DW'(cur_ptr), DW'(e.ptr));
            chk(e.req, "inv_mask", DW'(inv_mask), DW'(e.mask));
            chk(e.req, "ovf_trap", DW'(ovf_trap), DW'(e.ovf));
            chk(e.req, "unf_trap", DW'(unf_trap), DW'(e.unf));
        end
    end

    initial begin
        #800000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPHYS; i++) gold[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        cyc(1, 0, 0, 0, 0, 0, 3, 31);
        cyc(1, 0, 0, 0, 0, 0, 16, 8);
        // R2 global, R5 local, R4 out written in window 0
        cyc(2, 0, 0, 1, 3, 32'hA0A0_0003, 0, 0);
        cyc(5, 0, 0, 1, 16, 32'h1111_0016, 0, 0);
        cyc(4, 0, 0, 1, 8, 32'hB0B0_0008, 3, 16);
        // R3 write to r0 ignored
        cyc(3, 0, 0, 1, 0, 32'hFFFF_FFFF, 0, 8);
        cyc(3, 0, 0, 0, 0, 0, 0, 3);
        // R10 save with write r9 through old pointer; reads use old pointer
        cyc(10, 1, 0, 1, 9, 32'hC0C0_0009, 9, 8);
        // R6 wrap 0 -> 7; R4 outs of w0 are ins of w7
        cyc(4, 0, 0, 0, 0, 0, 24, 25);
        cyc(5, 0, 0, 0, 0, 0, 16, 3);
        // R6 walk down to window 2
        for (int i = 0; i < 5; i++) cyc(6, 1, 0, 1, 8, DW'(32'h5500 + i), 24, 8);
        // R8 target window 1 invalid
        cyc(8, 1, 0, 0, 0, 0, 24, 16);
        cyc(8, 0, 0, 0, 0, 0, 24, 8);
        // R7 climb back and wrap 7 -> 0
        for (int i = 0; i < 6; i++) cyc(7, 0, 1, 0, 0, 0, 8, 24);
        // R9 target window 1 invalid
        cyc(9, 0, 1, 0, 0, 0, 8, 16);
        cyc(9, 0, 0, 0, 0, 0, 8, 3);
        // R11 load overrides a save
        cyc(11, 1, 0, 0, 0, 0, 8, 8, 1, 3, 8'b0001_0000);
        cyc(11, 0, 1, 0, 0, 0, 8, 24);
        cyc(6, 1, 0, 0, 0, 0, 8, 24);
        // R12 save with restore at once
        cyc(12, 1, 1, 0, 0, 0, 8, 16);
        cyc(12, 0, 0, 0, 0, 0, 8, 16);
        // R4 restore direction: ins of w2 become outs of w3
        cyc(4, 0, 0, 1, 27, 32'hD0D0_0027, 27, 0);
        cyc(4, 0, 1, 0, 0, 0, 27, 11);
        cyc(4, 0, 0, 0, 0, 0, 11, 19);
        // R4 wrap alias between last window and window 0
        cyc(11, 0, 0, 0, 0, 0, 0, 0, 1, 7, '0);
        for (int r = 24; r < 32; r++) cyc(4, 0, 0, 1, r, DW'(32'h7700 + r), r, 3);
        cyc(11, 0, 0, 0, 0, 0, 0, 0, 1, 0, '0);
        for (int r = 8; r < 16; r++) cyc(4, 0, 0, 0, 0, 0, r, r + 16);
        // R5 R2 full window pattern in window 0 then window 5
        for (int r = 1; r < 32; r++) cyc(5, 0, 0, 1, r, DW'(32'h0500 + r), r, 31 - r);
        cyc(11, 0, 0, 0, 0, 0, 0, 0, 1, 5, '0);
        for (int r = 1; r < 32; r++) cyc(2, 0, 0, 0, 0, 0, r, 32 - r);
        @(posedge clk); @(negedge clk); #1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule